// File: doc/BRIEF.md
# Page Write Buffer Committer

This block is the write side of a small serial nonvolatile memory. A protocol engine in front of it has already decoded the bus: it hands over a starting word address, then one strobe per received data byte, and finally either a commit pulse when the bus stop arrives or an abort pulse when the transaction ends in some other way. Incoming bytes collect in a page-sized latch. Only the low offset bits of the address pointer advance, so a long burst wraps inside its own page. The commit copies the latch entries that were actually filled into the array page the pointer selects.

A valid commit starts a self-timed programming interval whose length in clock ticks is a parameter. The block reports that interval on `busy`, and all commands are refused while it lasts. The write-protect level is looked at only at the moment of the commit. A protected commit writes nothing, and the block is ready again at once. The array has a combinational read port, so the engine can fetch data, and that same port shows the array contents.

Top module: `pwb_committer`

## Requirements
- R1: After reset `busy` is 0 and `ptr` is 0.
- R2: A byte strobe stores the byte at latch offset `ptr[4:0]`, then raises `ptr[4:0]` by one modulo 32. `ptr[11:5]` is unchanged. A start strobe loads `ptr` from `start_addr`. When several strobes come in the same cycle, abort wins over commit, commit over start, and start over byte.
- R3: If more than 32 bytes arrive before the commit, a later byte replaces the earlier byte at the same offset. The array ends up holding the most recent byte for each offset.
- R4: The array does not change while bytes are only being received. It changes only on an accepted commit.
- R5: A commit with `wp` high writes nothing to the array and leaves `busy` at 0.
- R6: Changes of `wp` after an accepted commit have no effect on the write or on the length of the busy interval.
- R7: An accepted commit with at least one received byte and `wp` low raises `busy` in the next cycle and holds it for exactly `CYCLE_TICKS` cycles.
- R8: Start, byte and commit strobes that arrive while `busy` is high are ignored. They change neither `ptr` nor the array, and they do not lengthen `busy`.
- R9: After a transaction, `ptr` holds the address that follows the last byte received, with the wrap inside the page.
- R10: Only the offsets that received a byte are written. The other bytes of the page keep their previous contents.
- R11: An abort discards the latched bytes. A commit that follows it writes nothing and does not raise `busy`.
- R12: A commit that follows a start with no bytes writes nothing and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Load the word address and begin a new transaction |
| start_addr | input | 12 | Word address of the first byte |
| byte_vld | input | 1 | One received data byte |
| byte_data | input | 8 | Value of the received byte |
| commit | input | 1 | Bus stop that ends a write transaction |
| abort | input | 1 | Transaction ended without a write stop; the latch is discarded |
| wp | input | 1 | Write-protect level, sampled at commit |
| busy | output | 1 | Self-timed programming interval in progress |
| ptr | output | 12 | Current address pointer |
| rd_addr | input | 12 | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |

## Verification
A wrong fill mask or a wrong latch offset does not show while the bytes are arriving. It shows at the read port in the cycle after the commit, as a byte of the page that holds the wrong value. A pointer error shows on `ptr` one cycle after the strobe that caused it. A fault in the timer shows in the cycle where `busy` should have fallen or risen. The sweep reads back every byte of the committed page after each transaction, so any misplaced byte is reported before the next transaction starts.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_BYTE,
        OP_COMMIT,
        OP_ABORT
    } pwb_op_e;

    typedef struct packed {
        pwb_op_e    op;
        logic       wp;
    } pwb_cmd_t;

    function automatic pwb_op_e pwb_decode(input logic start_vld,
                                           input logic byte_vld,
                                           input logic commit,
                                           input logic abort);
        pwb_op_e r;
        if (abort)          r = OP_ABORT;
        else if (commit)    r = OP_COMMIT;
        else if (start_vld) r = OP_START;
        else if (byte_vld)  r = OP_BYTE;
        else                r = OP_NONE;
        return r;
    endfunction

endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  pwb_op_e                            op,
    input  logic [ADDR_W-1:0]                  start_addr,
    input  logic [DATA_W-1:0]                  byte_data,
    output logic [ADDR_W-1:0]                  ptr,
    output logic [PAGE_BYTES-1:0]              fill_mask,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  lane_data
);

    logic [OFS_W-1:0] ofs;
    assign ofs = ptr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (op == OP_START) begin
            ptr <= start_addr;
        end else if (op == OP_BYTE) begin
            ptr <= {ptr[ADDR_W-1:OFS_W], ofs + OFS_W'(1)};
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic hit;
        assign hit = (op == OP_BYTE) && (ofs == OFS_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                fill_mask[g] <= 1'b0;
            end else if (op == OP_START || op == OP_COMMIT || op == OP_ABORT) begin
                fill_mask[g] <= 1'b0;
            end else if (hit) begin
                fill_mask[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                lane_data[g] <= byte_data;
            end
        end
    end

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int CYCLE_TICKS = 1000,
    localparam int CNT_W      = $clog2(CYCLE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (launch && remain == '0) begin
            remain <= CNT_W'(CYCLE_TICKS);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFS_W,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic [PAGE_W-1:0]                  wr_page,
    input  logic [PAGE_BYTES-1:0]              wr_mask,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [DATA_W-1:0]                  rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (wr_mask[i]) begin
                    mem[{wr_page, OFS_W'(i)}] <= wr_data[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pwb_committer.sv
module pwb_committer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int CYCLE_TICKS = 1000,
    localparam int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    input  logic              wp,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    pwb_cmd_t                           cmd;
    logic [PAGE_BYTES-1:0]              fill_mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]  lane_data;
    logic                               launch;

    always_comb begin
        cmd.op = busy ? OP_NONE : pwb_decode(start_vld, byte_vld, commit, abort);
        cmd.wp = wp;
    end

    assign launch = (cmd.op == OP_COMMIT) && !cmd.wp && (|fill_mask);

    pwb_page_latch #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .op        (cmd.op),
        .start_addr(start_addr),
        .byte_data (byte_data),
        .ptr       (ptr),
        .fill_mask (fill_mask),
        .lane_data (lane_data)
    );

    pwb_array #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_array (
        .clk     (clk),
        .wr_en   (launch),
        .wr_page (ptr[ADDR_W-1:OFS_W]),
        .wr_mask (fill_mask),
        .wr_data (lane_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pwb_cycle_timer #(
        .CYCLE_TICKS(CYCLE_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .launch(launch),
        .busy  (busy)
    );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W      = 12,
    parameter int OFS_W       = 5,
    parameter int CYCLE_TICKS = 1000,
    localparam int CNT_W      = $clog2(CYCLE_TICKS + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start_vld,
    input logic              byte_vld,
    input logic              commit,
    input logic              abort,
    input logic              wp,
    input logic              busy,
    input logic [ADDR_W-1:0] ptr
);

    logic [CNT_W-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) high_cnt <= '0;
        else              high_cnt <= high_cnt + CNT_W'(1);
    end

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!busy && ptr == '0));

    // R2
    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !start_vld && !commit && !abort && !busy) |=>
        (ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W]) &&
         ptr[OFS_W-1:0] == $past(ptr[OFS_W-1:0]) + OFS_W'(1)));

    // R5
    p_protect_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (commit && !abort && wp && !busy) |=> !busy);

    // R7, R6
    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (high_cnt == CNT_W'(CYCLE_TICKS)));

    // R8
    p_busy_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptr));

    // R11
    p_abort_no_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (abort && !busy) |=> !busy);

endmodule

bind pwb_committer pwb_checker #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .CYCLE_TICKS(CYCLE_TICKS)
) u_pwb_checker (.*);

// File: tb/tb_pwb_committer.sv
module tb_pwb_committer;

    localparam int AW  = 12;
    localparam int CYC = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_vld = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic          wp = 1'b0;
    logic          busy;
    logic [AW-1:0] ptr;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] ref_mem   [1 << AW];
    bit         ref_known [1 << AW];
    logic [AW-1:0] exp_ptr;

    always #2 clk = ~clk;

    pwb_committer #(.ADDR_W(AW), .CYCLE_TICKS(CYC)) dut (
        .clk(clk), .rst(rst), .start_vld(start_vld), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit),
        .abort(abort), .wp(wp), .busy(busy), .ptr(ptr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_page(input string tag, input logic [AW-6:0] page);
        for (int i = 0; i < 32; i++) begin
            logic [AW-1:0] a;
            a = {page, 5'(i)};
            rd_addr = a;
            #0.1;
            if (ref_known[a]) chk(tag, rd_data, ref_mem[a]);
        end
    endtask

    // One transaction: start, n bytes, optional abort, commit with wp level,
    // optional injection of ignored strobes during busy.
    task automatic txn(input logic [AW-1:0] a, input int n, input int seed,
                       input bit wpv, input bit do_abort, input bit inject);
        logic [7:0] lat [32];
        bit         lm  [32];
        bit         valid;
        int         cnt;
        logic [AW-1:0] probe;
        for (int i = 0; i < 32; i++) lm[i] = 0;
        start_vld = 1; start_addr = a;
        @(negedge clk);
        start_vld = 0;
        exp_ptr = a;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1;
            byte_data = 8'((seed * 29) + (k * 13) + 7);
            lat[exp_ptr[4:0]] = byte_data;
            lm[exp_ptr[4:0]]  = 1;
            exp_ptr = {exp_ptr[AW-1:5], exp_ptr[4:0] + 5'd1};
            @(negedge clk);
            chk("R2 ptr advance", ptr, exp_ptr);
        end
        byte_vld = 0;
        probe = a;
        rd_addr = probe;
        #0.1;
        if (ref_known[probe]) chk("R4 no early write", rd_data, ref_mem[probe]);
        if (do_abort) begin
            abort = 1;
            @(negedge clk);
            abort = 0;
        end
        commit = 1; wp = wpv;
        @(negedge clk);
        commit = 0;
        valid = !wpv && !do_abort && (n > 0);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (inject) begin
                wp = cnt[0];
                byte_vld  = (cnt == 2);
                byte_data = 8'hEE;
                commit    = (cnt == 3);
                start_vld = (cnt == 4);
                start_addr = ~exp_ptr;
            end
            @(negedge clk);
        end
        byte_vld = 0; commit = 0; start_vld = 0; wp = 0;
        if (wpv)           chk("R5 protected busy", cnt, 0);
        else if (do_abort) chk("R11 aborted busy", cnt, 0);
        else if (n == 0)   chk("R12 empty busy", cnt, 0);
        else if (inject)   chk("R6 R8 busy length", cnt, CYC);
        else               chk("R7 busy length", cnt, CYC);
        chk(inject ? "R8 ptr ignored" : "R9 ptr after write", ptr, exp_ptr);
        if (valid) begin
            for (int i = 0; i < 32; i++) begin
                if (lm[i]) begin
                    ref_mem[{a[AW-1:5], 5'(i)}]   = lat[i];
                    ref_known[{a[AW-1:5], 5'(i)}] = 1;
                end
            end
        end
        if (n > 32)          check_page("R3 overflow page", a[AW-1:5]);
        else if (wpv)        check_page("R5 protected page", a[AW-1:5]);
        else if (do_abort)   check_page("R11 aborted page", a[AW-1:5]);
        else if (inject)     check_page("R8 page after busy", a[AW-1:5]);
        else                 check_page("R10 page content", a[AW-1:5]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens [8] = '{1, 3, 17, 31, 32, 33, 45, 64};
        int sts  [4] = '{0, 9, 30, 31};
        int trial = 0;
        for (int i = 0; i < (1 << AW); i++) ref_known[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 ptr reset", ptr, 0);

        // fill four pages completely so untouched bytes are known
        for (int p = 0; p < 4; p++) txn(AW'(p * 32 + 64), 32, p + 100, 0, 0, 0);

        // sweep lengths and start offsets
        foreach (lens[li]) begin
            foreach (sts[si]) begin
                logic [AW-1:0] a;
                a = AW'(((trial % 4) + 2) * 32 + sts[si]);
                txn(a, lens[li], trial, 0, 0, 0);
                trial++;
            end
        end

        // protected, aborted, empty and busy-injection cases
        for (int p = 0; p < 4; p++) begin
            txn(AW'((p + 2) * 32 + 5 * p), 7 + p, 200 + p, 1, 0, 0);
            txn(AW'((p + 2) * 32 + 3 * p), 5 + p, 300 + p, 0, 1, 0);
            txn(AW'((p + 2) * 32 + 11),    0,     400 + p, 0, 0, 0);
            txn(AW'((p + 2) * 32 + 2 * p), 4 + p, 500 + p, 0, 0, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule